// File: doc/BRIEF.md
# I2C Target with Address Match

This block is the receiving end of a two-wire serial bus. It watches the bus clock and data lines through a short synchronizer and finds start and stop conditions, including a start that is repeated in the middle of a transfer. After each start it collects an address byte. If the seven upper bits equal its own address, it answers with an acknowledge. It then hands received write bytes to the core as one-cycle strobes, or it serves read bytes that it fetches from the core through a request/valid pair. It never drives a line high. It only enables a pull-down on data, and a pull-down on clock while read data is still pending.

The own address comes in on a port. Two ranges can never be claimed as the target's own address: addresses whose upper four bits are 0000 and addresses whose upper four bits are 1111. In both cases the target stays silent, whatever the port holds. After an address mismatch, or after the bus master declines a read byte, the target ignores the bus until the next start.

Top module: `i2c_target`

## Requirements
- R1: While reset is asserted, both line pull-downs (`sda_oe`, `scl_oe`), `wr_valid` and `rd_req` are low.
- R2: A start (data falling while clock is high) or a stop (data rising while clock is high) is honoured at any bit position. After a partial byte cut off by either one, the next full address byte is framed from its first bit.
- R3: Serial bits are collected most significant bit first. Bit 0 of the address byte selects the direction: 0 means write and 1 means read.
- R4: When address bits [7:1] equal `dev_addr`, the target pulls data low through the ninth clock pulse. It releases the line after the falling clock edge that ends that pulse.
- R5: On an address mismatch the target gives no acknowledge. It drives neither line, strobes nothing and requests nothing until the next start.
- R6: An own address of 0000xxx or 1111xxx is never acknowledged, even when the incoming address equals it.
- R7: In a write transfer, each received data byte is acknowledged and appears on `wr_data` with exactly one one-cycle `wr_valid` pulse.
- R8: In a read transfer, each byte taken while `rd_req` and `rd_valid` are both high is shifted out most significant bit first. After an acknowledge from the master the next byte is requested. After a refusal no further request is raised.
- R9: A repeated start returns the target to address reception, so a write may be followed by a read without a stop in between.
- R10: `scl_oe` is high only from the end of an acknowledge clock in a read until the cycle after `rd_valid` is seen with `rd_req`. It is never high in a write or when no transfer is in progress.
- R11: The data pull-down changes only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_addr | input | 7 | Own 7-bit address |
| scl_oe | output | 1 | Pull bus clock low (clock stretch) |
| sda_oe | output | 1 | Pull bus data low |
| wr_data | output | 8 | Last received write byte |
| wr_valid | output | 1 | One-cycle strobe for `wr_data` |
| rd_req | output | 1 | Target wants the next read byte |
| rd_data | input | 8 | Read byte supplied by the core |
| rd_valid | input | 1 | `rd_data` is valid; accepted while `rd_req` is high |

## Verification
Two events can land in the same cycle. The first pair is the start of a clock stretch and the arrival of read data: a responder with zero latency raises `rd_valid` in the first cycle of `rd_req`. The bench then expects the stretch to end at once and the byte to come out intact. The second pair is start or stop detection and the bit framer. The bench cuts off an address byte after four bits with a repeated start, and after three bits with a stop. In both cases a fresh address must then be framed and acknowledged from its first bit.

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [6:0] dev_addr,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] wr_data,
  output logic       wr_valid,
  output logic       rd_req,
  input  logic [7:0] rd_data,
  input  logic       rd_valid
);

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK,
    ST_RD_WAIT, ST_RD, ST_RD_ACK, ST_SKIP
  } state_t;

  logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;
  state_t st;
  logic [3:0] cnt;
  logic [7:0] shreg;
  logic rw_q;

  wire scl_s = scl_pipe[SYNC_STAGES-1];
  wire sda_s = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
      scl_d    <= scl_s;
      sda_d    <= sda_s;
    end
  end

  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire addr_ok  = (dev_addr[6:3] != 4'b0000) && (dev_addr[6:3] != 4'b1111);
  wire match    = addr_ok && (shreg[7:1] == dev_addr);
  wire byte_end = scl_fall && (cnt == 4'd8);

  assign scl_oe = (st == ST_RD_WAIT);
  assign rd_req = (st == ST_RD_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_c) begin
        st     <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_c) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_WR: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], sda_s};
              cnt   <= cnt + 4'd1;
            end else if (byte_end) begin
              if (st == ST_WR) begin
                sda_oe   <= 1'b1;
                wr_data  <= shreg;
                wr_valid <= 1'b1;
                st       <= ST_WR_ACK;
              end else if (match) begin
                sda_oe <= 1'b1;
                rw_q   <= shreg[0];
                st     <= ST_ADDR_ACK;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= (st == ST_ADDR_ACK && rw_q) ? ST_RD_WAIT : ST_WR;
            end
          end
          ST_RD_WAIT: begin
            if (rd_valid) begin
              shreg  <= rd_data;
              sda_oe <= ~rd_data[7];
              cnt    <= '0;
              st     <= ST_RD;
            end
          end
          ST_RD: begin
            if (scl_rise) begin
              shreg <= {shreg[6:0], 1'b0};
              cnt   <= cnt + 4'd1;
            end else if (byte_end) begin
              sda_oe <= 1'b0;
              st     <= ST_RD_ACK;
            end else if (scl_fall) begin
              sda_oe <= ~shreg[7];
            end
          end
          ST_RD_ACK: begin
            if (scl_rise && sda_s) st <= ST_SKIP;
            else if (scl_fall)     st <= ST_RD_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

module i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic scl_oe,
  input logic rd_req,
  input logic rd_valid,
  input logic wr_valid
);

  // R11
  sda_edge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R10
  stretch_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> !scl_s);

  // R10
  stretch_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> !scl_oe);

  // R7
  wr_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  // R8
  wr_rd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !rd_req);

endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe), .scl_oe(scl_oe),
  .rd_req(rd_req), .rd_valid(rd_valid), .wr_valid(wr_valid)
);

// File: tb/i2c_target_test.sv
`timescale 1ns/1ps
module i2c_target_test;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic [6:0] dev_addr = 7'h2D;
  logic [7:0] rd_data = 8'h00;
  logic rd_valid = 1'b0;
  logic scl_oe, sda_oe, wr_valid, rd_req;
  logic [7:0] wr_data;
  wire scl_bus = m_scl & ~scl_oe;
  wire sda_bus = m_sda & ~sda_oe;

  int vectors = 0, fails = 0;
  int rd_delay = 0, wcnt = 0;
  logic [7:0] rdq[$];
  logic [7:0] got[$];

  always #4 clk = ~clk;

  i2c_target uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus), .dev_addr(dev_addr),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .wr_data(wr_data), .wr_valid(wr_valid),
    .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_x(input logic v, output logic s);
    m_sda = v; wq();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    wq(); s = sda_bus; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_start();
    m_sda = 1'b1; m_scl = 1'b1; wq();
    m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_rstart();
    m_sda = 1'b1; wq();
    m_scl = 1'b1;
    while (!scl_bus) @(negedge clk);
    wq(); m_sda = 1'b0; wq();
    m_scl = 1'b0; wq();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; wq();
    m_scl = 1'b1; wq();
    m_sda = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_x(b[i], s);
    bit_x(1'b1, s);
    ack = ~s;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] d);
    logic s;
    d = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, s);
      d = {d[6:0], s};
    end
    bit_x(~give_ack, s);
  endtask

  task automatic chk_wr(input string req, input logic [7:0] e[$]);
    chk(got.size() == e.size(), req, got.size(), e.size());
    for (int i = 0; i < e.size() && i < got.size(); i++)
      chk(got[i] == e[i], req, got[i], e[i]);
    got.delete();
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (wr_valid) got.push_back(wr_data);
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      rd_valid = 1'b0;
      if (rd_req) begin
        if (wcnt >= rd_delay) begin
          rd_valid = 1'b1;
          rd_data = (rdq.size() != 0) ? rdq.pop_front() : 8'hEE;
          wcnt = 0;
        end else wcnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] d;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk({sda_oe, scl_oe, wr_valid, rd_req} == 4'b0000, "R1 reset outputs",
        {sda_oe, scl_oe, wr_valid, rd_req}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R4 R7 R3 write transfer
    do_start();
    send_byte(8'h5A, a);
    chk(a == 1'b1, "R4 address ack", a, 1);
    chk(sda_oe == 1'b0, "R4 release after ninth clock", sda_oe, 0);
    send_byte(8'hA5, a); chk(a == 1'b1, "R7 data ack", a, 1);
    send_byte(8'h3C, a); chk(a == 1'b1, "R7 data ack", a, 1);
    send_byte(8'h01, a); chk(a == 1'b1, "R7 data ack", a, 1);
    chk(scl_oe == 1'b0, "R10 no stretch in write", scl_oe, 0);
    do_stop();
    chk_wr("R3 R7 write bytes msb first", '{8'hA5, 8'h3C, 8'h01});

    // R5 mismatch ignored until next start
    do_start();
    send_byte(8'h5C, a); chk(a == 1'b0, "R5 no ack on mismatch", a, 0);
    send_byte(8'h00, a); chk(a == 1'b0, "R5 ignores following byte", a, 0);
    chk({sda_oe, scl_oe, rd_req} == 3'b000, "R5 idle lines", {sda_oe, scl_oe, rd_req}, 0);
    do_stop();
    chk_wr("R5 no write strobes", '{});

    // R6 reserved own addresses
    dev_addr = 7'h07;
    do_start(); send_byte(8'h0E, a); do_stop();
    chk(a == 1'b0, "R6 reserved 0000xxx", a, 0);
    dev_addr = 7'h7C;
    do_start(); send_byte(8'hF8, a); do_stop();
    chk(a == 1'b0, "R6 reserved 1111xxx", a, 0);
    dev_addr = 7'h2D;

    // R2 repeated start mid-address, then full frame
    do_start();
    for (int i = 0; i < 4; i++) bit_x(1'b0, a);
    do_rstart();
    send_byte(8'h5A, a); chk(a == 1'b1, "R2 reframed after start", a, 1);
    send_byte(8'h77, a);
    do_stop();
    chk_wr("R2 write after reframe", '{8'h77});

    // R2 stop mid-address
    do_start();
    for (int i = 0; i < 3; i++) bit_x(1'b1, a);
    do_stop();
    do_start();
    send_byte(8'h5A, a); chk(a == 1'b1, "R2 reframed after stop", a, 1);
    send_byte(8'h42, a);
    do_stop();
    chk_wr("R2 write after stop", '{8'h42});

    // R8 R10 read with stretch
    rd_delay = 30;
    rdq.push_back(8'hC3); rdq.push_back(8'h96);
    do_start();
    send_byte(8'h5B, a); chk(a == 1'b1, "R4 read address ack", a, 1);
    chk(scl_oe == 1'b1 && rd_req == 1'b1, "R10 stretch while waiting", {scl_oe, rd_req}, 3);
    read_byte(1'b1, d); chk(d == 8'hC3, "R8 first read byte", d, 8'hC3);
    read_byte(1'b0, d); chk(d == 8'h96, "R8 second read byte", d, 8'h96);
    repeat (50) @(negedge clk);
    chk(rd_req == 1'b0 && scl_oe == 1'b0, "R8 no request after nack", {rd_req, scl_oe}, 0);
    do_stop();

    // R9 write then repeated start read, zero-latency data
    rd_delay = 0;
    rdq.push_back(8'h81);
    do_start();
    send_byte(8'h5A, a);
    send_byte(8'h10, a); chk(a == 1'b1, "R9 write before restart", a, 1);
    do_rstart();
    send_byte(8'h5B, a); chk(a == 1'b1, "R9 read address after restart", a, 1);
    read_byte(1'b0, d); chk(d == 8'h81, "R9 R10 read immediate data", d, 8'h81);
    do_stop();
    repeat (10) @(negedge clk);
    chk(scl_oe == 1'b0, "R10 released when idle", scl_oe, 0);
    chk_wr("R9 write byte", '{8'h10});

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule